// File: doc/BRIEF.md
# Fall-Through Bubble FIFO

This block is a first-in first-out buffer for 4-bit words. It is not a RAM addressed by read and write pointers. It is a chain of sixteen word stages, and each stage keeps its own occupancy marker. A stage that is empty takes the word from its occupied upstream neighbour and clears that neighbour's marker. As a result, words move toward the output end without outside control, and empty slots move back toward the input end.

The producer writes a word with a shift-in strobe while the input-ready flag is high. The consumer reads the word at the output with a shift-out strobe while the output-ready flag is high. The two sides can be strobed at unrelated rates. Words never overtake one another, and none is lost or repeated.

The model is single-clock. Every handoff is decided from the markers as they stood at the start of the cycle, so a word advances at most one stage per clock. The reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `bubble_fifo`

## Requirements
- R1: The buffer holds up to 16 words of 4 bits. With no shift-out, continuous shift-in strobes are accepted exactly 16 times.
- R2: After reset every stage is vacant: in_ready is 1 and out_ready is 0.
- R3: A word accepted into an empty buffer advances one stage per rising edge. out_ready rises on the 15th rising edge after the accepting edge, with that word on dout, and stays low on the 14th.
- R4: in_ready is high only while the input stage is vacant. A shift_in strobe while in_ready is low stores nothing.
- R5: out_ready is high whenever a word waits at the output stage, and dout then shows the oldest stored word.
- R6: A shift_out strobe while out_ready is low has no effect. It removes no later word and does not create a pending read.
- R7: Words leave in the order they were accepted, with none dropped or duplicated, under any mix of shift-in and shift-out rates.
- R8: On the edge that accepts a shift-out, the output stage becomes vacant, so out_ready is low in the following cycle.
- R9: A vacancy made at the output of a full buffer moves back one stage per edge. in_ready rises on the 15th rising edge after the accepting shift-out edge and stays low on the 14th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| din | input | 4 | Word to write |
| shift_in | input | 1 | Write strobe, taken only while in_ready is high |
| in_ready | output | 1 | Input stage vacant, a word can be written |
| dout | output | 4 | Oldest word, valid while out_ready is high |
| shift_out | input | 1 | Read strobe, taken only while out_ready is high |
| out_ready | output | 1 | A word waits at the output stage |

## Verification
Each flag and data result has a known due edge. The input-ready flag changes on the edge that accepts a write. The output-ready flag drops on the edge that accepts a read. A word written into an empty chain reaches the output fifteen edges later, and a vacancy made at the output of a full chain reaches the input fifteen edges after the read. The directed tasks count edges from the stimulus and sample on both sides of each due edge: the fourteenth edge must show the old value and the fifteenth the new one. All samples are taken two time units after the rising edge, so each one reflects exactly the edges counted. The random traffic phases decide acceptance from the flags sampled before each edge and compare every read against a queue model.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;

  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_FULL  = 1'b1
  } slot_state_e;

endpackage

// File: rtl/bfifo_rst_sync.sv
module bfifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/bfifo_stage.sv
module bfifo_stage
  import bfifo_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fill_avail,
  input  logic [W-1:0] fill_data,
  input  logic         drain_req,
  output logic         take,
  output logic         full,
  output logic [W-1:0] data
);

  slot_state_e state_q;
  slot_state_e state_d;
  logic [W-1:0] data_q;

  // A stage fills only while vacant, so it never fills and drains in one cycle.
  always_comb begin
    take    = fill_avail && (state_q == SLOT_EMPTY);
    state_d = state_q;
    if (take) begin
      state_d = SLOT_FULL;
    end else if (drain_req) begin
      state_d = SLOT_EMPTY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLOT_EMPTY;
    end else begin
      state_q <= state_d;
    end
  end

  // The data register has no reset; its content is qualified by the marker.
  always_ff @(posedge clk) begin
    if (take) begin
      data_q <= fill_data;
    end
  end

  assign full = (state_q == SLOT_FULL);
  assign data = data_q;

  // R3: a taken word is held in this stage on the next cycle.
  a_r3_copy: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (full && data == $past(fill_data)));

  // R7: an occupied stage that is not drained keeps its word unchanged.
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !drain_req) |=> (full && $stable(data)));

  // R9: a drained stage is vacant on the next cycle.
  a_r9_vacate: assert property (@(posedge clk) disable iff (!rst_n)
    (full && drain_req) |=> !full);

  // R6: a vacant stage stays vacant unless it takes a word.
  a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && !fill_avail) |=> !full);

endmodule

// File: rtl/bubble_fifo.sv
module bubble_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         shift_in,
  output logic         in_ready,
  output logic [W-1:0] dout,
  input  logic         shift_out,
  output logic         out_ready
);

  localparam int LAST = DEPTH - 1;

  logic rst_n_s;

  bfifo_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  logic [DEPTH-1:0] full;
  logic [DEPTH-1:0] take;
  logic [DEPTH-1:0] avail;
  logic [DEPTH-1:0] drain;
  logic [W-1:0]     src  [DEPTH];
  logic [W-1:0]     data [DEPTH];

  // Stage 0 is the input end and stage LAST is the output end.
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign avail[g] = shift_in;
      assign src[g]   = din;
    end else begin : g_body
      assign avail[g] = full[g-1];
      assign src[g]   = data[g-1];
    end

    if (g == LAST) begin : g_tail
      assign drain[g] = shift_out;
    end else begin : g_link
      assign drain[g] = take[g+1];
    end

    bfifo_stage #(.W(W)) u_stage (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .fill_avail (avail[g]),
      .fill_data  (src[g]),
      .drain_req  (drain[g]),
      .take       (take[g]),
      .full       (full[g]),
      .data       (data[g])
    );
  end

  assign in_ready  = !full[0];
  assign out_ready = full[LAST];
  assign dout      = data[LAST];

  // Checking aid: armed once one clean edge has passed after reset.
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
    end
  end

  logic push_ok;
  logic pop_ok;
  assign push_ok = shift_in && in_ready;
  assign pop_ok  = shift_out && out_ready;

  // R8: the output stage is empty on the cycle after an accepted read.
  a_r8_gap: assert property (@(posedge clk) disable iff (!rst_n_s)
    pop_ok |=> !out_ready);

  // R7: stored words change only by accepted writes and reads.
  a_r7_conserve: assert property (@(posedge clk) disable iff (!rst_n_s)
    armed_q |-> ($countones(full) ==
      $past($countones(full)) + int'($past(push_ok)) - int'($past(pop_ok))));

  // R4: a write refused while the input stage is occupied leaves it occupied.
  a_r4_refuse: assert property (@(posedge clk) disable iff (!rst_n_s)
    (shift_in && !in_ready && !take[1]) |=> !in_ready);

  // R2: the stage markers are all clear after reset.
  always_ff @(posedge clk) begin
    if (!rst_n_s) begin
      a_r2_clear: assert (full == '0);
    end
  end

endmodule

// File: tb/test_bubble_fifo.sv
module test_bubble_fifo;

  logic       clk;
  logic       rst_n;
  logic [3:0] din;
  logic       shift_in;
  logic       in_ready;
  logic [3:0] dout;
  logic       shift_out;
  logic       out_ready;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [3:0] model_q [$];

  bubble_fifo i_bubble_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .shift_in  (shift_in),
    .in_ready  (in_ready),
    .dout      (dout),
    .shift_out (shift_out),
    .out_ready (out_ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; shift_in = 1'b0; shift_out = 1'b0; din = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    chk(in_ready == 1'b1, "R2 in_ready after reset", in_ready, 1);
    chk(out_ready == 1'b0, "R2 out_ready after reset", out_ready, 0);
  endtask

  task automatic test_latency();
    din = 4'hA; shift_in = 1'b1;
    tick();
    shift_in = 1'b0;
    repeat (14) tick();
    chk(out_ready == 1'b0, "R3 out_ready on 14th edge", out_ready, 0);
    tick();
    chk(out_ready == 1'b1, "R3 out_ready on 15th edge", out_ready, 1);
    chk(dout == 4'hA, "R5 dout holds word", dout, 4'hA);
    shift_out = 1'b1;
    tick();
    shift_out = 1'b0;
    chk(out_ready == 1'b0, "R8 out_ready after read", out_ready, 0);
    repeat (20) tick();
    chk(out_ready == 1'b0, "R7 no duplicate after read", out_ready, 0);
  endtask

  task automatic test_empty_read();
    shift_out = 1'b1;
    repeat (5) tick();
    shift_out = 1'b0;
    chk(out_ready == 1'b0, "R6 empty read ignored", out_ready, 0);
    din = 4'h5; shift_in = 1'b1;
    tick();
    shift_in = 1'b0;
    repeat (15) tick();
    chk(out_ready == 1'b1, "R6 word not consumed by earlier read", out_ready, 1);
    chk(dout == 4'h5, "R6 word value", dout, 4'h5);
    shift_out = 1'b1;
    tick();
    shift_out = 1'b0;
    repeat (20) tick();
    chk(out_ready == 1'b0, "R6 buffer empty again", out_ready, 0);
  endtask

  task automatic test_fill_drain();
    int acc = 0;
    int wait_n;
    din = 4'h0; shift_in = 1'b1;
    for (int i = 0; i < 60; i++) begin
      automatic logic ir = in_ready;
      tick();
      if (ir) begin
        acc++;
        din = din + 4'h1;
      end
    end
    shift_in = 1'b0;
    chk(acc == 16, "R1 accepted words", acc, 16);
    chk(in_ready == 1'b0, "R4 in_ready low when full", in_ready, 0);
    chk(out_ready == 1'b1 && dout == 4'h0, "R5 oldest word at output", dout, 0);
    shift_out = 1'b1;
    tick();
    shift_out = 1'b0;
    repeat (14) tick();
    chk(in_ready == 1'b0, "R9 in_ready on 14th edge", in_ready, 0);
    tick();
    chk(in_ready == 1'b1, "R9 in_ready on 15th edge", in_ready, 1);
    for (int e = 1; e < 16; e++) begin
      wait_n = 0;
      while (!out_ready && wait_n < 40) begin
        tick();
        wait_n++;
      end
      chk(out_ready && dout == e[3:0], "R7 drain order", dout, e);
      shift_out = 1'b1;
      tick();
      shift_out = 1'b0;
      chk(out_ready == 1'b0, "R8 gap after read", out_ready, 0);
    end
    repeat (40) tick();
    chk(out_ready == 1'b0, "R4 refused writes not stored", out_ready, 0);
  endtask

  task automatic test_mixed(input int cycles, input int pin, input int pout);
    int bad = 0;
    int guard = 0;
    for (int c = 0; c < cycles + 2000; c++) begin
      automatic logic si;
      automatic logic so;
      automatic logic ir = in_ready;
      automatic logic orr = out_ready;
      automatic logic [3:0] dv = dout;
      automatic logic [3:0] nv = 4'($urandom);
      if (c < cycles) begin
        si = (($urandom % 100) < pin);
        so = (($urandom % 100) < pout);
      end else begin
        si = 1'b0;
        so = 1'b1;
        if (model_q.size() == 0) break;
      end
      din = nv; shift_in = si; shift_out = so;
      tick();
      if (si && ir) model_q.push_back(nv);
      if (so && orr) begin
        if (model_q.size() == 0) begin
          bad++;
        end else begin
          automatic logic [3:0] ev = model_q.pop_front();
          if (dv != ev) begin
            bad++;
            $display("FAIL R7 read value actual=%0d expected=%0d", dv, ev);
          end
        end
      end
      guard++;
    end
    shift_in = 1'b0; shift_out = 1'b0;
    chk(bad == 0, "R7 mixed traffic mismatches", bad, 0);
    chk(model_q.size() == 0, "R7 all words drained", model_q.size(), 0);
    repeat (20) tick();
    chk(out_ready == 1'b0, "R7 no extra word", out_ready, 0);
    model_q.delete();
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    test_latency();
    test_empty_read();
    test_fill_drain();
    test_mixed(1500, 70, 20);
    test_mixed(1500, 20, 70);
    test_mixed(1000, 50, 50);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule